// File: doc/BRIEF.md
# Codec Power-Down Controller

This block decides, cycle by cycle on the master clock, whether a voice codec is active or in its low-power state. Two things put it to sleep: the active-low sleep pin, once it has been synchronized, or a stretch of master-clock cycles in which neither the transmit nor the receive frame sync is seen while the bit clock keeps toggling. It wakes only when the sleep pin is high, the bit clock is running and a transmit frame sync arrives.

The `pwr_down` output is meant to drive the high-impedance control of the analog and reference outputs. The `dt_oe` output enables the serial transmit data driver. After every wake-up it stays low until a set number of further transmit frame syncs have been counted. That count starts from zero again on every new entry into the low-power state.

Top module: `pwrdn_ctrl`

## Requirements
- R1: During and after reset, `pwr_down` is 1 and `dt_oe` is 0 until a wake-up occurs.
- R2: A 0 on `pd_n` passes through a SYNC_STAGES-flop synchronizer. With the default two stages, `pwr_down` goes to 1 on the third rising `mclk` edge after `pd_n` falls.
- R3: Take E1 as the first `mclk` edge at which both syncs are sampled low. If both stay low with the bit clock active, `pwr_down` goes to 1 on edge E(IDLE_CYCLES+1). A new `fs_tx` pulse sampled high at edge E(IDLE_CYCLES) or earlier prevents this.
- R4: `fs_rx` pulses alone, spaced less than IDLE_CYCLES apart, keep the block awake.
- R5: When `bclk` has shown no edge for STALL_CYCLES `mclk` cycles, the idle count holds, and no idle power-down occurs however long the syncs stay low.
- R6: Wake-up needs all three of: `pd_n` high after synchronization, the bit clock active, and a rising edge on `fs_tx`. `pwr_down` returns to 0 on the second `mclk` edge after `fs_tx` is first sampled high. An `fs_rx` pulse never wakes the block.
- R7: After a wake-up, `dt_oe` stays 0 until GUARD_PULSES further rising edges of `fs_tx` have been seen. It goes to 1 on the second `mclk` edge after the last of those edges is first sampled high.
- R8: The guard count restarts at zero on every entry into the low-power state.
- R9: `dt_oe` is 0 whenever `pwr_down` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all state is clocked by it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low sleep pin |
| bclk | input | 1 | Bit clock, watched only for activity |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| pwr_down | output | 1 | 1 while in the low-power state |
| dt_oe | output | 1 | Output enable for the transmit data driver |

## Verification
The hardest case to reach is the exact boundary of the idle timeout. Here a keep-alive sync lands either on the last edge where it still saves the active state, or one edge too late. The bench sweeps the gap between two transmit syncs across that boundary while the bit clock runs, and checks the state right after the edge that decides it. A second hard case is an idle stretch with the bit clock stopped. The bench gates its bit clock generator to produce it, and then shows that neither a timeout nor a wake-up can happen without bit clock activity.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
   typedef enum logic {
      PST_SLEEP = 1'b0,
      PST_AWAKE = 1'b1
   } pstate_e;
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
   parameter int STAGES = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pdc_activity.sv
module pdc_activity #(
   parameter int SYNC_STAGES  = 2,
   parameter int STALL_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic active
);
   localparam int SW = $clog2(STALL_CYCLES + 1);
   localparam logic [SW-1:0] STALL_MAX = SW'(STALL_CYCLES);

   logic          sig_s;
   logic          sig_d;
   logic [SW-1:0] quiet_cnt;

   pdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sig_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (sig),
      .q    (sig_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_d     <= 1'b0;
         quiet_cnt <= STALL_MAX;
      end else begin
         sig_d <= sig_s;
         if (sig_s != sig_d)
            quiet_cnt <= '0;
         else if (quiet_cnt != STALL_MAX)
            quiet_cnt <= quiet_cnt + 1'b1;
      end
   end

   assign active = (quiet_cnt != STALL_MAX);
endmodule

// File: rtl/pdc_idle_timer.sv
module pdc_idle_timer #(
   parameter int IDLE_CYCLES = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic advance,
   output logic expired
);
   localparam int CW = $clog2(IDLE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clear)          cnt <= '0;
      else if (advance) begin
         if (cnt != LAST)      cnt <= cnt + 1'b1;
         else                  cnt <= '0;
      end
   end

   assign expired = advance && !clear && (cnt == LAST);
endmodule

// File: rtl/pdc_guard.sv
module pdc_guard #(
   parameter int GUARD_PULSES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic pulse,
   output logic done
);
   generate
      if (GUARD_PULSES == 0) begin : g_none
         assign done = 1'b1;
      end else begin : g_count
         localparam int GW = $clog2(GUARD_PULSES + 1);
         localparam logic [GW-1:0] GMAX = GW'(GUARD_PULSES);
         logic [GW-1:0] seen;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      seen <= '0;
            else if (clear)                  seen <= '0;
            else if (pulse && seen != GMAX)  seen <= seen + 1'b1;
         end

         assign done = (seen == GMAX);
      end
   endgenerate
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
   import pwrdn_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int IDLE_CYCLES  = 512,
   parameter int STALL_CYCLES = 64,
   parameter int GUARD_PULSES = 2
) (
   input  logic mclk,
   input  logic rst_n,
   input  logic pd_n,
   input  logic bclk,
   input  logic fs_tx,
   input  logic fs_rx,
   output logic pwr_down,
   output logic dt_oe
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pwrdn_ctrl: SYNC_STAGES must be at least 2");
      end
      if (IDLE_CYCLES < 2) begin : g_bad_idle
         $error("pwrdn_ctrl: IDLE_CYCLES must be at least 2");
      end
      if (STALL_CYCLES < 2) begin : g_bad_stall
         $error("pwrdn_ctrl: STALL_CYCLES must be at least 2");
      end
      if (GUARD_PULSES < 0) begin : g_bad_guard
         $error("pwrdn_ctrl: GUARD_PULSES must not be negative");
      end
   endgenerate

   pstate_e state;
   logic    pd_ok;
   logic    bclk_act;
   logic    fs_tx_r, fs_tx_rr, fs_rx_r;
   logic    tx_rise;
   logic    idle_clear, idle_adv, idle_exp;
   logic    guard_done;

   pdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_sync (
      .clk  (mclk),
      .rst_n(rst_n),
      .d    (pd_n),
      .q    (pd_ok)
   );

   pdc_activity #(.SYNC_STAGES(SYNC_STAGES), .STALL_CYCLES(STALL_CYCLES)) u_bclk_mon (
      .clk   (mclk),
      .rst_n (rst_n),
      .sig   (bclk),
      .active(bclk_act)
   );

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         fs_tx_r  <= 1'b0;
         fs_tx_rr <= 1'b0;
         fs_rx_r  <= 1'b0;
      end else begin
         fs_tx_r  <= fs_tx;
         fs_tx_rr <= fs_tx_r;
         fs_rx_r  <= fs_rx;
      end
   end

   assign tx_rise    = fs_tx_r && !fs_tx_rr;
   assign idle_clear = (state == PST_SLEEP) || fs_tx_r || fs_rx_r;
   assign idle_adv   = bclk_act;

   pdc_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
      .clk    (mclk),
      .rst_n  (rst_n),
      .clear  (idle_clear),
      .advance(idle_adv),
      .expired(idle_exp)
   );

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PST_SLEEP;
      end else begin
         unique case (state)
            PST_SLEEP: if (pd_ok && bclk_act && tx_rise) state <= PST_AWAKE;
            PST_AWAKE: if (!pd_ok || idle_exp)           state <= PST_SLEEP;
            default:                                     state <= PST_SLEEP;
         endcase
      end
   end

   pdc_guard #(.GUARD_PULSES(GUARD_PULSES)) u_guard (
      .clk  (mclk),
      .rst_n(rst_n),
      .clear(state == PST_SLEEP),
      .pulse(tx_rise),
      .done (guard_done)
   );

   assign pwr_down = (state == PST_SLEEP);
   assign dt_oe    = (state == PST_AWAKE) && guard_done;
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk #(
   parameter int GUARD_PULSES = 2
) (
   input logic mclk,
   input logic rst_n,
   input logic pd_n,
   input logic fs_rx,
   input logic pwr_down,
   input logic dt_oe
);
   a_r9_oe_off_asleep: assert property (@(posedge mclk) disable iff (!rst_n)
      pwr_down |-> !dt_oe);

   a_r2_pin_sleeps: assert property (@(posedge mclk) disable iff (!rst_n)
      (!pd_n && $past(!pd_n) && $past(!pd_n, 2)) |=> pwr_down);

   a_r4_rx_keeps_awake: assert property (@(posedge mclk) disable iff (!rst_n)
      ($past(fs_rx) && $past(pd_n, 2) && !pwr_down) |=> !pwr_down);

   generate
      if (GUARD_PULSES > 0) begin : g_guard_chk
         a_r7_wake_holds_oe: assert property (@(posedge mclk) disable iff (!rst_n)
            $fell(pwr_down) |-> !dt_oe);
         a_r7_oe_after_awake: assert property (@(posedge mclk) disable iff (!rst_n)
            $rose(dt_oe) |-> $past(!pwr_down));
      end
   endgenerate
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk #(.GUARD_PULSES(GUARD_PULSES)) chk_i (
   .mclk    (mclk),
   .rst_n   (rst_n),
   .pd_n    (pd_n),
   .fs_rx   (fs_rx),
   .pwr_down(pwr_down),
   .dt_oe   (dt_oe)
);

// File: tb/pwrdn_ctrl_tb_top.sv
module pwrdn_ctrl_tb_top;
   localparam int IDLE  = 40;
   localparam int STALL = 16;
   localparam int GUARD = 2;

   logic clk = 1'b0;
   logic rst_n, pd_n, bclk, fs_tx, fs_rx, bclk_en;
   logic pwr_down, dt_oe;
   int   n_checks = 0;
   int   n_err    = 0;
   bit   done     = 1'b0;

   always #2 clk = ~clk;

   pwrdn_ctrl #(
      .SYNC_STAGES (2),
      .IDLE_CYCLES (IDLE),
      .STALL_CYCLES(STALL),
      .GUARD_PULSES(GUARD)
   ) dut_i (
      .mclk    (clk),
      .rst_n   (rst_n),
      .pd_n    (pd_n),
      .bclk    (bclk),
      .fs_tx   (fs_tx),
      .fs_rx   (fs_rx),
      .pwr_down(pwr_down),
      .dt_oe   (dt_oe)
   );

   initial begin
      bclk = 1'b0;
      forever begin
         @(negedge clk);
         @(negedge clk);
         if (bclk_en) bclk = ~bclk;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic pulse_tx();
      fs_tx = 1'b1;
      tick(1);
      fs_tx = 1'b0;
   endtask

   task automatic pulse_rx();
      fs_rx = 1'b1;
      tick(1);
      fs_rx = 1'b0;
   endtask

   task automatic ensure_up();
      if (pwr_down) begin
         pulse_tx();
         tick(3);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; pd_n = 1'b1; fs_tx = 1'b0; fs_rx = 1'b0; bclk_en = 1'b1;
      tick(5);
      chk("R1 reset pwr_down", pwr_down, 1'b1);
      chk("R1 reset dt_oe", dt_oe, 1'b0);
      rst_n = 1'b1;
      tick(20);
      chk("R1 still asleep after reset", pwr_down, 1'b1);

      // R6: wake exactly on the second edge after fs_tx is sampled high
      pulse_tx();
      chk("R6 not yet awake after one edge", pwr_down, 1'b1);
      tick(1);
      chk("R6 awake on second edge", pwr_down, 1'b0);
      chk("R7 dt_oe low at wake", dt_oe, 1'b0);

      // R7: guard of two further transmit syncs
      pulse_tx(); tick(3);
      chk("R7 dt_oe low after first guard sync", dt_oe, 1'b0);
      pulse_tx();
      chk("R7 dt_oe low one edge into second sync", dt_oe, 1'b0);
      tick(1);
      chk("R7 dt_oe high after second guard sync", dt_oe, 1'b1);

      // R3: sweep the keep-alive gap across the timeout boundary
      for (int j = IDLE - 3; j <= IDLE + 2; j++) begin
         ensure_up();
         pulse_tx();
         tick(j - 1);
         fs_tx = 1'b1;
         tick(1);
         fs_tx = 1'b0;
         chk($sformatf("R3 gap %0d", j), pwr_down, (j >= IDLE + 1) ? 1'b1 : 1'b0);
         if (j >= IDLE + 1) chk("R9 dt_oe off after timeout", dt_oe, 1'b0);
         tick(4);
      end

      // R4: receive syncs alone keep the block awake
      ensure_up();
      pulse_tx();
      for (int k = 0; k < 8; k++) begin
         tick(IDLE - 12);
         pulse_rx();
         chk("R4 fs_rx keep-alive", pwr_down, 1'b0);
      end

      // R5: stalled bit clock freezes the idle count
      ensure_up();
      pulse_tx();
      bclk_en = 1'b0;
      tick(3 * IDLE);
      chk("R5 no timeout without bit clock", pwr_down, 1'b0);
      pulse_tx();
      bclk_en = 1'b1;
      tick(6);
      chk("R5 awake after bit clock resumes", pwr_down, 1'b0);

      // R2: pin-driven sleep latency
      ensure_up();
      pulse_tx(); tick(3);
      pulse_tx(); tick(3);
      chk("R7 dt_oe high before pin sleep", dt_oe, 1'b1);
      pd_n = 1'b0;
      tick(2);
      chk("R2 awake two edges after pin", pwr_down, 1'b0);
      tick(1);
      chk("R2 asleep on third edge", pwr_down, 1'b1);
      chk("R9 dt_oe off while asleep", dt_oe, 1'b0);

      // R6: blocked wake conditions
      pulse_tx(); tick(4);
      chk("R6 no wake with pin low", pwr_down, 1'b1);
      pd_n = 1'b1;
      tick(4);
      pulse_rx(); tick(4);
      chk("R6 fs_rx does not wake", pwr_down, 1'b1);
      bclk_en = 1'b0;
      tick(2 * STALL);
      pulse_tx(); tick(4);
      chk("R6 no wake with bit clock stalled", pwr_down, 1'b1);
      bclk_en = 1'b1;
      tick(6);
      pulse_tx(); tick(1);
      chk("R6 wake with all conditions", pwr_down, 1'b0);

      // R8: guard count restarted by the new sleep
      pulse_tx(); tick(3);
      chk("R8 guard restarted, one sync", dt_oe, 1'b0);
      pulse_tx(); tick(1);
      chk("R8 guard restarted, two syncs", dt_oe, 1'b1);

      done = 1'b1;
      finish_run();
   end
endmodule